// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for an eight-input, twelve-bit successive-approximation acquisition channel. It latches a three-bit input selector when the strobe falls, and it starts a conversion when chip enable and the active-low read/convert line are both in their active state. It runs one bit trial per clock against an external comparator, from the most significant bit down. It then parks the finished code in an output register. A status flag marks the busy window. The data bus is driven only while the block is idle, enabled and in read mode.

The analog selector, track-and-hold, trial DAC and comparator are outside the block. The block presents the selected input index and the current trial word, and it reads back one comparator bit per trial.

Top module: `das_conv_ctrl`

## Requirements
- R1: On a cycle where `latch_strobe` is sampled low after being sampled high, `addr` is captured. Code k (0 to 7) selects input k on `chan_sel` when idle. A rising or steady strobe leaves the captured value unchanged.
- R2: A conversion starts on the clock where `ce`=1 and `rc_n`=0 first hold together. Either signal may complete the condition, or both may change in the same cycle.
- R3: While `ce` is 0, no conversion starts and `data_oe` stays 0, whatever `rc_n` does.
- R4: At start the result register is cleared. In the first trial cycle `dac_word` has only bit N_BITS-1 set (0x800 by default).
- R5: After a start, further start conditions are ignored until the busy window ends. A start condition still held when the conversion ends does not begin a new one.
- R6: `busy` rises STAT_DLY clocks after the start edge and stays high for exactly N_BITS+LEAD_CYC clocks.
- R7: Each trial cycle sets the current bit in `dac_word`. If `cmp_below`=1 (input below trial value), the bit is cleared, otherwise it is kept. The final code is the largest value not exceeding the input.
- R8: The finished code enters the output register LEAD_CYC clocks before `busy` falls. The bus is never driven from the start edge until `busy` falls.
- R9: When idle, `data_oe`=1 exactly when `ce`=1 and `rc_n`=1, and `data_bus` then carries the stored code with bit i high meaning 2^i. When `data_oe`=0 the bus is high impedance.
- R10: `chan_sel` holds the index captured at the start edge for the whole conversion, even if the strobe falls meanwhile.
- R11: Reset clears `busy`, the stored result, the trial word and the captured index, so `chan_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ce | input | 1 | Chip enable, high to allow reads or starts |
| rc_n | input | 1 | Low requests a conversion, high requests a read |
| latch_strobe | input | 1 | Selector capture on falling edge |
| addr | input | 3 | Input selector code |
| cmp_below | input | 1 | Comparator: analog input below trial word |
| chan_sel | output | 3 | Input index to the analog selector |
| dac_word | output | 12 | Trial word to the DAC |
| busy | output | 1 | Status, high during conversion |
| data_bus | output | 12 | Result bus, high impedance unless enabled |
| data_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a second start condition, or a selector strobe, arriving in the middle of a conversion that is already running. From outside, both look like legal activity. The stimulus counts busy cycles as they pass and, at chosen points inside the window, raises `rc_n`, lowers it again and bounces `ce`. It also pulses the strobe with a new code. It then checks that the busy width, the selected index and the final code are those of the first conversion, and that nothing new starts once `busy` falls.

// File: rtl/das_pkg.sv
package das_pkg;
  typedef enum logic [1:0] {
    CV_IDLE   = 2'd0,
    CV_SETTLE = 2'd1,
    CV_TRIAL  = 2'd2,
    CV_HOLD   = 2'd3
  } cv_state_e;
endpackage

// File: rtl/das_start_det.sv
module das_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic rc_n,
  output logic start_req
);
  logic arm_d, arm_q;

  always_comb arm_d = ce & ~rc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  // the later of the two inputs to become active completes the condition
  assign start_req = arm_d & ~arm_q;
endmodule

// File: rtl/das_chan_latch.sv
module das_chan_latch #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              freeze,
  input  logic              conv_active,
  output logic [ADDR_W-1:0] chan_cap,
  output logic [ADDR_W-1:0] chan_sel
);
  logic              stb_q;
  logic              cap_en, frz_en;
  logic [ADDR_W-1:0] cap_d, cap_q, frz_d, frz_q;

  always_comb begin
    cap_en = stb_q & ~strobe;
    frz_en = freeze;
    cap_d  = cap_en ? addr  : cap_q;
    frz_d  = frz_en ? cap_q : frz_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      cap_q <= '0;
      frz_q <= '0;
    end else begin
      stb_q <= strobe;
      cap_q <= cap_d;
      frz_q <= frz_d;
    end
  end

  assign chan_cap = cap_q;
  assign chan_sel = conv_active ? frz_q : cap_q;
endmodule

// File: rtl/das_sar_seq.sv
module das_sar_seq
  import das_pkg::*;
#(
  parameter int N_BITS   = 12,
  parameter int STAT_DLY = 2,
  parameter int LEAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              cmp_below,
  output logic              start_acc,
  output logic              conv_active,
  output logic              busy,
  output logic [N_BITS-1:0] dac_word,
  output logic              result_load,
  output logic [N_BITS-1:0] result
);
  localparam int CNT_MAX = (STAT_DLY > LEAD_CYC) ? STAT_DLY : LEAD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IDX_W   = (N_BITS > 1) ? $clog2(N_BITS) : 1;

  cv_state_e         st_d, st_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q;
  logic [IDX_W-1:0]  idx_d, idx_q;
  logic [N_BITS-1:0] sar_d, sar_q;
  logic [N_BITS-1:0] trial_bit;
  logic              busy_d, busy_q;

  always_comb begin
    trial_bit        = '0;
    trial_bit[idx_q] = 1'b1;
  end

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    sar_d       = sar_q;
    busy_d      = busy_q;
    start_acc   = 1'b0;
    result_load = 1'b0;
    unique case (st_q)
      CV_IDLE: begin
        if (start_req) begin
          start_acc = 1'b1;
          st_d      = CV_SETTLE;
          cnt_d     = CNT_W'(STAT_DLY - 1);
          sar_d     = '0;
        end
      end
      CV_SETTLE: begin
        if (cnt_q == '0) begin
          st_d   = CV_TRIAL;
          idx_d  = IDX_W'(N_BITS - 1);
          busy_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      CV_TRIAL: begin
        sar_d[idx_q] = ~cmp_below;
        if (idx_q == '0) begin
          st_d        = CV_HOLD;
          cnt_d       = CNT_W'(LEAD_CYC - 1);
          result_load = 1'b1;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
      CV_HOLD: begin
        if (cnt_q == '0) begin
          st_d   = CV_IDLE;
          busy_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CV_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sar_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sar_q  <= sar_d;
      busy_q <= busy_d;
    end
  end

  assign conv_active = (st_q != CV_IDLE);
  assign busy        = busy_q;
  assign dac_word    = (st_q == CV_TRIAL) ? (sar_q | trial_bit) : sar_q;
  assign result      = sar_d;
endmodule

// File: rtl/das_out_port.sv
module das_out_port #(
  parameter int N_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [N_BITS-1:0] result,
  input  logic              ce,
  input  logic              rc_n,
  input  logic              conv_active,
  output logic              data_oe,
  output logic [N_BITS-1:0] data_bus
);
  logic [N_BITS-1:0] out_d, out_q;

  always_comb out_d = load ? result : out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign data_oe  = ce & rc_n & ~conv_active;
  assign data_bus = data_oe ? out_q : 'z;
endmodule

// File: rtl/das_conv_ctrl.sv
module das_conv_ctrl #(
  parameter  int N_BITS   = 12,
  parameter  int N_CH     = 8,
  parameter  int STAT_DLY = 2,
  parameter  int LEAD_CYC = 4,
  localparam int ADDR_W   = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              rc_n,
  input  logic              latch_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cmp_below,
  output logic [ADDR_W-1:0] chan_sel,
  output logic [N_BITS-1:0] dac_word,
  output logic              busy,
  output logic [N_BITS-1:0] data_bus,
  output logic              data_oe
);
  logic              start_req, start_acc, conv_active, result_load;
  logic [N_BITS-1:0] result;
  logic [ADDR_W-1:0] chan_cap;

  das_start_det u_start (
    .clk(clk), .rst_n(rst_n), .ce(ce), .rc_n(rc_n), .start_req(start_req)
  );

  das_chan_latch #(.ADDR_W(ADDR_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .strobe(latch_strobe), .addr(addr),
    .freeze(start_acc), .conv_active(conv_active),
    .chan_cap(chan_cap), .chan_sel(chan_sel)
  );

  das_sar_seq #(.N_BITS(N_BITS), .STAT_DLY(STAT_DLY), .LEAD_CYC(LEAD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cmp_below(cmp_below),
    .start_acc(start_acc), .conv_active(conv_active), .busy(busy),
    .dac_word(dac_word), .result_load(result_load), .result(result)
  );

  das_out_port #(.N_BITS(N_BITS)) u_out (
    .clk(clk), .rst_n(rst_n), .load(result_load), .result(result),
    .ce(ce), .rc_n(rc_n), .conv_active(conv_active),
    .data_oe(data_oe), .data_bus(data_bus)
  );
endmodule

// File: rtl/das_conv_ctrl_chk.sv
module das_conv_ctrl_chk #(
  parameter int N_BITS   = 12,
  parameter int ADDR_W   = 3,
  parameter int LEAD_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              data_oe,
  input logic              latch_strobe,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] chan_cap,
  input logic [ADDR_W-1:0] chan_sel,
  input logic [N_BITS-1:0] dac_word,
  input logic              result_load
);
  logic [15:0] busy_run, since_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run   <= '0;
      since_load <= '0;
    end else begin
      busy_run <= busy ? busy_run + 16'd1 : 16'd0;
      if (result_load)            since_load <= 16'd0;
      else if (since_load != '1)  since_load <= since_load + 16'd1;
    end
  end

  // R1
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(latch_strobe) && !latch_strobe) |=> (chan_cap == $past(addr)));

  // R4
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dac_word == (N_BITS'(1) << (N_BITS - 1))));

  // R6
  busy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 16'(N_BITS + LEAD_CYC)));

  // R8
  load_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (since_load == 16'(LEAD_CYC)));

  // R8
  no_drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_oe);

  // R10
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_sel));
endmodule

bind das_conv_ctrl das_conv_ctrl_chk #(
  .N_BITS(N_BITS), .ADDR_W(ADDR_W), .LEAD_CYC(LEAD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .data_oe(data_oe),
  .latch_strobe(latch_strobe), .addr(addr), .chan_cap(chan_cap),
  .chan_sel(chan_sel), .dac_word(dac_word), .result_load(result_load)
);

// File: tb/das_conv_ctrl_bench.sv
module das_conv_ctrl_bench;
  localparam int NB    = 12;
  localparam int SDLY  = 2;
  localparam int LEAD  = 4;
  localparam int RISE  = SDLY + 1;
  localparam int WIDTH = NB + LEAD;

  logic          clk = 1'b0;
  logic          rst_n, ce, rc_n, latch_strobe, cmp_below;
  logic [2:0]    addr, chan_sel;
  logic [NB-1:0] dac_word, data_bus, target;
  logic          busy, data_oe;
  int            n_chk = 0;
  int            n_err = 0;

  always #10 clk = ~clk;

  assign cmp_below = (target < dac_word);

  das_conv_ctrl u_das_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .rc_n(rc_n), .latch_strobe(latch_strobe),
    .addr(addr), .cmp_below(cmp_below), .chan_sel(chan_sel), .dac_word(dac_word),
    .busy(busy), .data_bus(data_bus), .data_oe(data_oe)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [2:0] a);
    @(negedge clk); addr = a; latch_strobe = 1'b1;
    @(negedge clk); latch_strobe = 1'b0;
    @(negedge clk);
  endtask

  // Caller has just driven the start condition at a negedge.
  task automatic measure(output int rise, output int width, output int first_dac);
    rise = 0;
    do begin @(negedge clk); rise++; end while (!busy && rise < 60);
    first_dac = int'(dac_word);
    width = 0;
    while (busy && width < 200) begin
      if (data_oe) chk(1'b0, "R8 bus driven while busy", 1, 0);
      width++;
      @(negedge clk);
    end
  endtask

  task automatic read_back(input logic [NB-1:0] exp, input string req);
    ce = 1'b1; rc_n = 1'b1; #1;
    chk(data_oe == 1'b1, {req, " R9 oe"}, int'(data_oe), 1);
    chk(data_bus == exp, {req, " R9 data"}, int'(data_bus), int'(exp));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce = 1'b0; rc_n = 1'b1; latch_strobe = 1'b0; addr = 3'd5; target = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11 busy", int'(busy), 0);
    chk(chan_sel == 3'd0, "R11 chan_sel", int'(chan_sel), 0);
    chk(dac_word == '0, "R11 dac_word", int'(dac_word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ce = 1'b1; #1;
    chk(data_bus == '0, "R11 result cleared", int'(data_bus), 0);
    ce = 1'b0;
  endtask

  task automatic t_addr();
    for (int k = 0; k < 8; k++) begin
      latch_addr(3'(k));
      chk(chan_sel == 3'(k), "R1 capture", int'(chan_sel), k);
    end
    latch_addr(3'd3);
    @(negedge clk); addr = 3'd6; latch_strobe = 1'b1;
    repeat (2) @(negedge clk); addr = 3'd1;
    repeat (2) @(negedge clk);
    chk(chan_sel == 3'd3, "R1 held on rise and steady high", int'(chan_sel), 3);
    latch_strobe = 1'b0;
    @(negedge clk);
    chk(chan_sel == 3'd1, "R1 fall captures", int'(chan_sel), 1);
  endtask

  task automatic t_basic(input logic [NB-1:0] tgt);
    int r, w, d;
    target = tgt; ce = 1'b1;
    @(negedge clk); rc_n = 1'b0;
    measure(r, w, d);
    chk(r == RISE, "R6 busy rise delay", r, RISE);
    chk(w == WIDTH, "R6 busy width", w, WIDTH);
    chk(d == (1 << (NB - 1)), "R4 first trial word", d, 1 << (NB - 1));
    read_back(tgt, "R7");
  endtask

  task automatic t_ce_gate();
    int r, w, d;
    target = 12'h3C7;
    @(negedge clk); ce = 1'b0; rc_n = 1'b1; #1;
    chk(data_oe == 1'b0, "R3 read blocked", int'(data_oe), 0);
    rc_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R3 start blocked", int'(busy), 0);
    ce = 1'b1;
    measure(r, w, d);
    chk(r == RISE, "R2 ce completes start", r, RISE);
    read_back(12'h3C7, "R2");
    @(negedge clk); ce = 1'b0; rc_n = 1'b1;
    @(negedge clk); ce = 1'b1; rc_n = 1'b0; target = 12'h155;
    measure(r, w, d);
    chk(r == RISE, "R2 simultaneous start", r, RISE);
    read_back(12'h155, "R2");
  endtask

  task automatic t_no_restart();
    int w, r;
    target = 12'h9B2;
    @(negedge clk); ce = 1'b1; rc_n = 1'b0;
    r = 0;
    do begin @(negedge clk); r++; end while (!busy && r < 60);
    w = 0;
    while (busy && w < 200) begin
      w++;
      if (w == 3) begin rc_n = 1'b1; #1;
        chk(data_oe == 1'b0, "R8 no read during conversion", int'(data_oe), 0); end
      if (w == 5) rc_n = 1'b0;
      if (w == 7) ce = 1'b0;
      if (w == 8) ce = 1'b1;
      @(negedge clk);
    end
    chk(w == WIDTH, "R5 width unchanged by restarts", w, WIDTH);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R5 held condition no new start", int'(busy), 0);
    read_back(12'h9B2, "R5");
  endtask

  task automatic t_freeze();
    int w;
    latch_addr(3'd2);
    target = 12'h0F0;
    @(negedge clk); ce = 1'b1; rc_n = 1'b0;
    do @(negedge clk); while (!busy);
    addr = 3'd6; latch_strobe = 1'b1;
    @(negedge clk); latch_strobe = 1'b0;
    w = 0;
    while (busy && w < 200) begin
      if (chan_sel != 3'd2) chk(1'b0, "R10 frozen select", int'(chan_sel), 2);
      w++;
      @(negedge clk);
    end
    chk(chan_sel == 3'd2 || chan_sel == 3'd6, "R10 select settled", int'(chan_sel), 6);
    chk(chan_sel == 3'd6, "R1 captured during conversion", int'(chan_sel), 6);
    read_back(12'h0F0, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_addr();
    t_basic(12'h000);
    t_basic(12'hFFF);
    t_basic(12'h800);
    t_basic(12'h7FF);
    t_basic(12'hA5A);
    t_ce_gate();
    t_no_restart();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule